// File: doc/BRIEF.md
# Coarse-to-Fine Motion Vector Search Controller

This block steers a two-phase block-matching search for one macroblock over a window of ±8 pixels on each axis, which holds 289 candidate displacements. It does not touch pixels. It tells nine external distortion lanes which displacement each lane should score, collects the scores the lanes return, and picks the lowest score. Each lane returns its score after its own latency.

In the coarse phase the controller walks nine lattice rows, one per step. The rows are spaced two pixels apart vertically. The rows take turns between a nine-point pattern on even columns and an eight-point pattern on odd columns, which gives 77 coarse points. A comparator tree reduces each step's returned scores to one minimum. After the coarse phase comes a single fine step, which scores the eight unit-distance neighbours of the best coarse point, diagonals included. Neighbours that fall outside the window are not issued. The lowest score over both phases is reported with a one-cycle done pulse.

Top module: `mv_search_ctrl`

## Requirements
- R1: While reset is held and after it is released, `done` and `probe_go` are 0, and `mv_x`, `mv_y` and `mv_cost` are 0.
- R2: The coarse phase takes 9 steps, k = 0..8, and every lane of step k has dy = 2k-8. When k is even, lanes 0..8 are enabled with dx = 2i-8. When k is odd, lanes 0..7 are enabled with dx = 2i-7 and lane 8 is disabled. This gives 77 enabled coarse candidates.
- R3: Each step begins with a `probe_go` pulse one cycle long. The lane offsets and enables then hold steady until every enabled lane has returned a cost. Only the first cost-valid from an enabled lane within a step is taken. Cost-valid from a disabled lane, or a repeated one, has no effect on the result.
- R4: Exactly one fine step follows the coarse phase. Lanes 0..7 carry the coarse winner plus these (dx,dy) deltas, in lane order: (-1,-1), (0,-1), (1,-1), (-1,0), (1,0), (-1,1), (0,1), (1,1). Lane 8 is disabled. A lane whose position lies outside -8..+8 on either axis is disabled.
- R5: The result is the lowest cost over all coarse and fine candidates. On equal cost the candidate evaluated first wins. Evaluation order is step order, then lane index within a step.
- R6: `done` is high for exactly one cycle per search. With it, `mv_x` and `mv_y` carry the winning displacement as signed two's-complement 5-bit values and `mv_cost` carries its 16-bit cost. These outputs hold until the next search completes.
- R7: A `start` sampled while idle produces the first `probe_go` in the next cycle. A `start` sampled while a search is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search when idle |
| lane_cost_vld | input | 9 | Per-lane cost strobe |
| lane_cost | input | 144 | Per-lane cost, lane i at bits [16i+15:16i] |
| probe_go | output | 1 | Step issue pulse |
| lane_en | output | 9 | Lanes that take part in the current step |
| lane_dx | output | 45 | Per-lane horizontal offset, signed 5 bits, lane i at [5i+4:5i] |
| lane_dy | output | 45 | Per-lane vertical offset, signed 5 bits |
| done | output | 1 | Result pulse |
| mv_x | output | 5 | Winning horizontal displacement |
| mv_y | output | 5 | Winning vertical displacement |
| mv_cost | output | 16 | Winning cost |

## Verification
A smooth bowl-shaped cost is centred on each of the 289 window positions in turn. This shows whether the fine step finds the true minimum from every possible coarse winner, including the corners and edges where neighbours are masked. A flat cost makes every candidate tie, which checks that the first-evaluated position (-8,-8) wins and that the fine step cannot displace an equal coarse winner. Pseudo-random hashed costs with several seeds give minima that are not unimodal. Throughout all patterns, lane latencies are staggered, zero-cost strobes are injected on disabled lanes and as repeats, and `start` is pulsed during a running search, so that result changes would expose any capture or restart fault.

// File: rtl/mvs_pkg.sv
package mvs_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} srch_state_e;
  typedef enum logic {PH_COARSE, PH_FINE} srch_phase_e;

  localparam int FINE_N = 8;

  // neighbour order: top row left to right, middle left/right, bottom row
  function automatic int fine_dx(input int idx);
    case (idx)
      0, 3, 5: return -1;
      1, 6:    return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int fine_dy(input int idx);
    case (idx)
      0, 1, 2: return -1;
      3, 4:    return 0;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/mvs_lattice.sv
module mvs_lattice
  import mvs_pkg::*;
#(
  parameter int RANGE = 8,
  parameter int LANES = RANGE + 1,
  parameter int MV_W  = 5,
  parameter int ROW_W = 4
) (
  input  srch_phase_e              phase,
  input  logic [ROW_W-1:0]         row,
  input  logic signed [MV_W-1:0]   ctr_x,
  input  logic signed [MV_W-1:0]   ctr_y,
  output logic [LANES*MV_W-1:0]    lane_dx,
  output logic [LANES*MV_W-1:0]    lane_dy,
  output logic [LANES-1:0]         lane_en
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin : lane_calc
      int vx;
      int vy;
      logic on;
      vx = 0;
      vy = 0;
      on = 1'b0;
      if (phase == PH_COARSE) begin
        vy = 2 * int'(row) - RANGE;
        if (!row[0]) begin
          vx = 2 * g - RANGE;
          on = 1'b1;
        end else begin
          vx = 2 * g + 1 - RANGE;
          on = (g < LANES - 1);
        end
      end else if (g < FINE_N) begin
        vx = int'(ctr_x) + fine_dx(g);
        vy = int'(ctr_y) + fine_dy(g);
        on = (vx >= -RANGE) && (vx <= RANGE) && (vy >= -RANGE) && (vy <= RANGE);
      end
      lane_dx[g*MV_W +: MV_W] = MV_W'(vx);
      lane_dy[g*MV_W +: MV_W] = MV_W'(vy);
      lane_en[g]              = on;
    end
  end

endmodule

// File: rtl/mvs_capture.sv
module mvs_capture #(
  parameter int LANES  = 9,
  parameter int COST_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      cap_en,
  input  logic [LANES-1:0]          lane_en,
  input  logic [LANES-1:0]          cost_vld,
  input  logic [LANES*COST_W-1:0]   cost_in,
  output logic [LANES-1:0]          cap_vld,
  output logic [LANES*COST_W-1:0]   cap_cost,
  output logic                      all_in
);

  logic [LANES-1:0]        vld_n;
  logic [LANES*COST_W-1:0] cost_n;

  for (genvar g = 0; g < LANES; g++) begin : g_cap
    always_comb begin
      vld_n[g]                   = cap_vld[g];
      cost_n[g*COST_W +: COST_W] = cap_cost[g*COST_W +: COST_W];
      if (clr) begin
        vld_n[g] = 1'b0;
      end else if (cap_en && lane_en[g] && cost_vld[g] && !cap_vld[g]) begin
        vld_n[g]                   = 1'b1;
        cost_n[g*COST_W +: COST_W] = cost_in[g*COST_W +: COST_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vld  <= '0;
      cap_cost <= '0;
    end else begin
      cap_vld  <= vld_n;
      cap_cost <= cost_n;
    end
  end

  assign all_in = &(cap_vld | ~lane_en);

endmodule

// File: rtl/mvs_min_tree.sv
module mvs_min_tree #(
  parameter int N      = 9,
  parameter int COST_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic [N-1:0]          in_vld,
  input  logic [N*COST_W-1:0]   in_cost,
  output logic                  out_vld,
  output logic [COST_W-1:0]     out_cost,
  output logic [IDX_W-1:0]      out_idx
);

  localparam int LVL   = (N > 1) ? $clog2(N) : 1;
  localparam int NP    = 1 << LVL;
  localparam int NODES = 2 * NP - 1;

  logic              nv [NODES];
  logic [COST_W-1:0] nc [NODES];
  logic [IDX_W-1:0]  ni [NODES];

  for (genvar g = 0; g < NP; g++) begin : g_leaf
    if (g < N) begin : g_real
      assign nv[NP-1+g] = in_vld[g];
      assign nc[NP-1+g] = in_cost[g*COST_W +: COST_W];
      assign ni[NP-1+g] = IDX_W'(g);
    end else begin : g_pad
      assign nv[NP-1+g] = 1'b0;
      assign nc[NP-1+g] = '0;
      assign ni[NP-1+g] = '0;
    end
  end

  // left subtree always holds lower lane indices: ties resolve to the left
  for (genvar n = 0; n < NP - 1; n++) begin : g_node
    logic pick_l;
    assign pick_l = nv[2*n+1] && (!nv[2*n+2] || (nc[2*n+1] <= nc[2*n+2]));
    assign nv[n]  = nv[2*n+1] | nv[2*n+2];
    assign nc[n]  = pick_l ? nc[2*n+1] : nc[2*n+2];
    assign ni[n]  = pick_l ? ni[2*n+1] : ni[2*n+2];
  end

  assign out_vld  = nv[0];
  assign out_cost = nc[0];
  assign out_idx  = ni[0];

endmodule

// File: rtl/mv_search_ctrl.sv
module mv_search_ctrl
  import mvs_pkg::*;
#(
  parameter int RANGE  = 8,
  parameter int COST_W = 16,
  parameter int LANES  = RANGE + 1,
  parameter int MV_W   = $clog2(RANGE + 1) + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [LANES-1:0]          lane_cost_vld,
  input  logic [LANES*COST_W-1:0]   lane_cost,
  output logic                      probe_go,
  output logic [LANES-1:0]          lane_en,
  output logic [LANES*MV_W-1:0]     lane_dx,
  output logic [LANES*MV_W-1:0]     lane_dy,
  output logic                      done,
  output logic signed [MV_W-1:0]    mv_x,
  output logic signed [MV_W-1:0]    mv_y,
  output logic [COST_W-1:0]         mv_cost
);

  localparam int ROW_W = $clog2(RANGE + 1);
  localparam int IDX_W = $clog2(LANES);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(RANGE);

  srch_state_e             state_q, state_n;
  srch_phase_e             phase_q, phase_n;
  logic [ROW_W-1:0]        row_q, row_n;
  logic                    best_vld_q, best_vld_n;
  logic [COST_W-1:0]       best_cost_q, best_cost_n;
  logic signed [MV_W-1:0]  best_x_q, best_x_n, best_y_q, best_y_n;
  logic                    done_n;
  logic signed [MV_W-1:0]  mv_x_n, mv_y_n;
  logic [COST_W-1:0]       mv_cost_n;

  logic [LANES-1:0]        cap_vld;
  logic [LANES*COST_W-1:0] cap_cost;
  logic                    all_in;
  logic                    tree_vld;
  logic [COST_W-1:0]       tree_cost;
  logic [IDX_W-1:0]        tree_idx;
  logic signed [MV_W-1:0]  win_x, win_y;
  logic                    step_better;

  mvs_lattice #(.RANGE(RANGE), .LANES(LANES), .MV_W(MV_W), .ROW_W(ROW_W)) i_lattice (
    .phase(phase_q), .row(row_q), .ctr_x(best_x_q), .ctr_y(best_y_q),
    .lane_dx(lane_dx), .lane_dy(lane_dy), .lane_en(lane_en)
  );

  mvs_capture #(.LANES(LANES), .COST_W(COST_W)) i_capture (
    .clk(clk), .rst_n(rst_n), .clr(state_q == ST_ISSUE), .cap_en(state_q == ST_WAIT),
    .lane_en(lane_en), .cost_vld(lane_cost_vld), .cost_in(lane_cost),
    .cap_vld(cap_vld), .cap_cost(cap_cost), .all_in(all_in)
  );

  mvs_min_tree #(.N(LANES), .COST_W(COST_W), .IDX_W(IDX_W)) i_tree (
    .in_vld(cap_vld & lane_en), .in_cost(cap_cost),
    .out_vld(tree_vld), .out_cost(tree_cost), .out_idx(tree_idx)
  );

  always_comb begin
    win_x = '0;
    win_y = '0;
    for (int i = 0; i < LANES; i++) begin
      if (tree_idx == IDX_W'(i)) begin
        win_x = lane_dx[i*MV_W +: MV_W];
        win_y = lane_dy[i*MV_W +: MV_W];
      end
    end
  end

  // strict compare across steps: an earlier step keeps a tie
  assign step_better = tree_vld && (!best_vld_q || (tree_cost < best_cost_q));
  assign probe_go    = (state_q == ST_ISSUE);

  always_comb begin
    state_n     = state_q;
    phase_n     = phase_q;
    row_n       = row_q;
    best_vld_n  = best_vld_q;
    best_cost_n = best_cost_q;
    best_x_n    = best_x_q;
    best_y_n    = best_y_q;
    done_n      = 1'b0;
    mv_x_n      = mv_x;
    mv_y_n      = mv_y;
    mv_cost_n   = mv_cost;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_n    = ST_ISSUE;
          phase_n    = PH_COARSE;
          row_n      = '0;
          best_vld_n = 1'b0;
        end
      end
      ST_ISSUE: state_n = ST_WAIT;
      ST_WAIT: begin
        if (all_in) begin
          if (step_better) begin
            best_vld_n  = 1'b1;
            best_cost_n = tree_cost;
            best_x_n    = win_x;
            best_y_n    = win_y;
          end
          if (phase_q == PH_COARSE) begin
            state_n = ST_ISSUE;
            if (row_q == LAST_ROW) phase_n = PH_FINE;
            else                   row_n   = row_q + 1'b1;
          end else begin
            state_n   = ST_IDLE;
            done_n    = 1'b1;
            mv_x_n    = best_x_n;
            mv_y_n    = best_y_n;
            mv_cost_n = best_cost_n;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      phase_q     <= PH_COARSE;
      row_q       <= '0;
      best_vld_q  <= 1'b0;
      best_cost_q <= '0;
      best_x_q    <= '0;
      best_y_q    <= '0;
      done        <= 1'b0;
      mv_x        <= '0;
      mv_y        <= '0;
      mv_cost     <= '0;
    end else begin
      state_q     <= state_n;
      phase_q     <= phase_n;
      row_q       <= row_n;
      best_vld_q  <= best_vld_n;
      best_cost_q <= best_cost_n;
      best_x_q    <= best_x_n;
      best_y_q    <= best_y_n;
      done        <= done_n;
      mv_x        <= mv_x_n;
      mv_y        <= mv_y_n;
      mv_cost     <= mv_cost_n;
    end
  end

  // ---------------- assertions ----------------
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_go_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    probe_go |=> !probe_go);

  assert_go_has_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    probe_go |-> (lane_en != '0));

  assert_coarse_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_go && phase_q == PH_COARSE) |->
      ($countones(lane_en) == (row_q[0] ? LANES - 1 : LANES)));

  assert_offsets_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !all_in) |=> ($stable(lane_dx) && $stable(lane_dy) && $stable(lane_en)));

  assert_start_issues_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start) |=> probe_go);

  assert_mv_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mv_x >= -RANGE && mv_x <= RANGE && mv_y >= -RANGE && mv_y <= RANGE));

  assert_best_falls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (best_vld_q && $past(best_vld_q)) |-> (best_cost_q <= $past(best_cost_q)));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    assert_tree_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && all_in && lane_en[g] && cap_vld[g]) |->
        (tree_vld && tree_cost <= cap_cost[g*COST_W +: COST_W]));
  end

endmodule

// File: tb/test_mv_search_ctrl.sv
module test_mv_search_ctrl;

  localparam int L = 9;
  localparam int CW = 16;
  localparam int VW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [L-1:0]    lane_vld = '0;
  logic [L*CW-1:0] lane_cost = '0;
  logic            probe_go;
  logic [L-1:0]    lane_en;
  logic [L*VW-1:0] lane_dx, lane_dy;
  logic            done;
  logic signed [VW-1:0] mv_x, mv_y;
  logic [CW-1:0]   mv_cost;

  always #5 clk = ~clk;

  mv_search_ctrl i_mv_search_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_cost_vld(lane_vld), .lane_cost(lane_cost),
    .probe_go(probe_go), .lane_en(lane_en), .lane_dx(lane_dx), .lane_dy(lane_dy),
    .done(done), .mv_x(mv_x), .mv_y(mv_y), .mv_cost(mv_cost)
  );

  int checks = 0, failures = 0;
  int mode = 0, tx = 0, ty = 0, seed = 0, search_no = 0;
  int exp_x, exp_y, exp_c, ccx, ccy;
  int go_cnt, done_cnt, coarse_total;
  bit finished = 0;

  int cnt [L];
  bit pend [L];
  bit en_at_go [L];
  int ox [L], oy [L];
  int since_go = 0;
  bit dup = 0, prev_done = 0;

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int costf(input int x, input int y);
    case (mode)
      0: return 4 * (iabs(x - tx) + iabs(y - ty)) + (((x + 8) * 3 + (y + 8) * 5) % 4);
      1: return 100;
      default: return ((x + 8) * 37 + (y + 8) * 91 + seed * 17) % 251 + 1;
    endcase
  endfunction

  function automatic int fdx(input int i);
    if (i == 0 || i == 3 || i == 5) return -1;
    if (i == 1 || i == 6) return 0;
    return 1;
  endfunction

  function automatic int fdy(input int i);
    if (i < 3) return -1;
    if (i < 5) return 0;
    return 1;
  endfunction

  // expected result from R2, R4 and R5 in evaluation order
  task automatic model();
    int b;
    b = 1 << 30;
    for (int k = 0; k < 9; k++) begin
      for (int i = 0; i < L; i++) begin
        int x, y;
        if (k % 2 == 1 && i == L - 1) continue;
        x = (k % 2 == 0) ? 2 * i - 8 : 2 * i - 7;
        y = 2 * k - 8;
        if (costf(x, y) < b) begin b = costf(x, y); ccx = x; ccy = y; end
      end
    end
    exp_x = ccx; exp_y = ccy; exp_c = b;
    for (int i = 0; i < 8; i++) begin
      int x, y;
      x = ccx + fdx(i); y = ccy + fdy(i);
      if (x < -8 || x > 8 || y < -8 || y > 8) continue;
      if (costf(x, y) < exp_c) begin exp_c = costf(x, y); exp_x = x; exp_y = y; end
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  // lane model, step monitor and result monitor
  always @(negedge clk) begin
    if (rst_n) begin
      lane_vld = '0;
      if (probe_go) begin
        bit ok;
        int bad_e, bad_a;
        ok = 1; bad_e = 0; bad_a = 0;
        for (int i = 0; i < L; i++) begin
          bit een;
          int ex, ey, ax, ay;
          ax = $signed(lane_dx[i*VW +: VW]);
          ay = $signed(lane_dy[i*VW +: VW]);
          if (go_cnt < 9) begin
            ey = 2 * go_cnt - 8;
            ex = (go_cnt % 2 == 0) ? 2 * i - 8 : 2 * i - 7;
            een = (go_cnt % 2 == 0) || (i < L - 1);
          end else begin
            ex = ccx + fdx(i); ey = ccy + fdy(i);
            een = (i < 8) && ex >= -8 && ex <= 8 && ey >= -8 && ey <= 8;
          end
          if (lane_en[i] != een) begin ok = 0; bad_a = lane_en[i]; bad_e = een; end
          else if (een && (ax != ex || ay != ey)) begin ok = 0; bad_a = ax * 100 + ay; bad_e = ex * 100 + ey; end
          pend[i] = lane_en[i];
          en_at_go[i] = lane_en[i];
          cnt[i] = 1 + ((i * 3 + go_cnt + search_no) % 4);
          ox[i] = ax; oy[i] = ay;
        end
        if (go_cnt < 9) begin
          check(ok, "R2 coarse lane offsets/enables", bad_a, bad_e);
          coarse_total += $countones(lane_en);
        end else begin
          check(ok, "R4 fine lane offsets/enables", bad_a, bad_e);
        end
        go_cnt++;
        since_go = 0;
        dup = 0;
      end else begin
        since_go++;
        if (dup) begin lane_vld[0] = 1'b1; lane_cost[0 +: CW] = '0; dup = 0; end
        for (int i = 0; i < L; i++) begin
          if (pend[i]) begin
            cnt[i]--;
            if (cnt[i] == 0) begin
              lane_vld[i] = 1'b1;
              lane_cost[i*CW +: CW] = CW'(costf(ox[i], oy[i]));
              pend[i] = 0;
              if (i == 0) dup = 1;
            end
          end
          // R3 noise: zero cost on disabled lanes must be ignored
          if (since_go == 1 && !en_at_go[i]) begin
            lane_vld[i] = 1'b1;
            lane_cost[i*CW +: CW] = '0;
          end
        end
      end
      if (done) begin
        done_cnt++;
        check(mv_x == exp_x && mv_y == exp_y && mv_cost == exp_c, "R5 result vector/cost",
              mv_x * 10000 + mv_y * 1000 + mv_cost, exp_x * 10000 + exp_y * 1000 + exp_c);
      end
      if (done && prev_done) check(0, "R6 done longer than one cycle", 2, 1);
      prev_done = done;
    end
  end

  task automatic run_search(input int m, input int ax, input int ay, input int sd, input bit poke);
    int waited;
    mode = m; tx = ax; ty = ay; seed = sd;
    model();
    search_no++;
    go_cnt = 0; done_cnt = 0; coarse_total = 0;
    @(negedge clk); #1;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    check(go_cnt == 1, "R7 first probe_go one cycle after start", go_cnt, 1);
    if (poke) begin
      repeat (4) @(negedge clk);
      #1 start = 1'b1;
      @(negedge clk); #1 start = 1'b0;
    end
    waited = 0;
    while (done_cnt == 0 && waited < 3000) begin
      @(negedge clk); #1;
      waited++;
    end
    if (done_cnt == 0) check(0, "R6 no done within timeout", 0, 1);
    repeat (3) @(negedge clk);
    #1;
    check(done_cnt == 1 && go_cnt == 10, "R7 one search per start (done*100+steps)",
          done_cnt * 100 + go_cnt, 110);
    check(coarse_total == 77, "R2 coarse candidate total", coarse_total, 77);
    check(!done && mv_x == exp_x && mv_y == exp_y && mv_cost == exp_c, "R6 result held after done",
          mv_x * 10000 + mv_y * 1000 + mv_cost, exp_x * 10000 + exp_y * 1000 + exp_c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !probe_go && mv_x == 0 && mv_y == 0 && mv_cost == 0, "R1 state in reset",
          done + probe_go + mv_cost, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!done && !probe_go && mv_x == 0 && mv_y == 0 && mv_cost == 0, "R1 state after reset",
          done + probe_go + mv_cost, 0);
    // R5 tie: flat cost, first evaluated point wins
    run_search(1, 0, 0, 0, 0);
    check(exp_x == -8 && exp_y == -8, "R5 tie model sanity", exp_x, -8);
    // smooth bowl centred on every window position
    for (int y = -8; y <= 8; y++)
      for (int x = -8; x <= 8; x++)
        run_search(0, x, y, 0, 0);
    // hashed costs, with start pulsed mid-search (R7)
    for (int s = 0; s < 16; s++) run_search(2, 0, 0, s, 1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule